// File: doc/BRIEF.md
# Light-Sensor Register Port over I2C

This block is the two-wire serial slave of an ambient-light sensor controller. It samples the clock and data lines with the system clock and answers only the fixed device address. It holds the configuration of the sensor core and hands that configuration to the converter and interrupt logic as plain output fields. Those neighbours feed the latest conversion result and timer count back in, and the block returns them on reads.

A host writes in one transaction: the device address with the write bit, then a register-select byte, then an optional data byte. To read, the host first sets the register pointer with a write, then sends a repeated start, the address with the read bit, and clocks out one byte, which it ends with a NAK. The two top bits of the register-select byte are not part of the address. They are write-only command strobes: one requests an integration sync and the other clears the interrupt. Each fires as a single-cycle pulse.

Top module: `lsense_i2c_regs`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 7'b1000100. On any other address it leaves SDA released for the rest of the transaction and changes no register.
- R2: A data byte written to pointer 0 sets the command register. The command fields map as follows: bit 7 to `adc_enable`, bit 6 to `adc_powerdown`, bit 5 to `ext_timing`, bits 3:2 to `diode_sel` and bits 1:0 to `width_sel`. Bit 4 always reads back as 0.
- R3: Bits 5:0 of the register-select byte set the pointer. A read after a repeated start returns the register at that pointer. Pointer 0 is the command register, 1 control, 2 high threshold and 3 low threshold. Pointers 4 and 5 are `sensor_i` low and high bytes, and pointers 6 and 7 are `timer_i` low and high bytes. Pointers 8 and above read 0x00.
- R4: Writes to pointers 4 and above change nothing, and such a read still returns the live input bytes.
- R5: A register-select byte with bit 7 set gives exactly one cycle of `sync_pulse`, and its bits 5:0 still update the pointer.
- R6: A register-select byte with bit 6 set gives exactly one cycle of `clr_pulse` and clears `int_flag`.
- R7: After reset, `thr_hi` is 0xFF, `thr_lo` is 0x00, all command and control fields are 0, `int_flag` is 0, and SDA is released.
- R8: A one-cycle `alarm_set_i` sets `int_flag`. Writing the control register with bit 5 at 0 clears it, and writing bit 5 at 1 never sets it. A clear wins over a set in the same cycle.
- R9: The control register reads as {0, 0, int_flag, 0, gain, persist}. Bits 3:2 drive `gain_sel` and bits 1:0 drive `persist_sel`, and written values in bits 7, 6 and 4 are dropped.
- R10: SDA is pulled low only in the acknowledge slots of received bytes and for the 0 bits of read data. A NAK from the host after a read byte ends the transfer.
- R11: A stop condition before the data byte leaves all registers unchanged, but the pointer from the register-select byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| sensor_i | input | 16 | Latest conversion result |
| timer_i | input | 16 | Timer count that belongs to the latest result |
| alarm_set_i | input | 1 | Interrupt evaluator request to set the flag |
| adc_enable | output | 1 | Converter enable |
| adc_powerdown | output | 1 | Power-down request |
| ext_timing | output | 1 | 1 = integration timed by host sync strobes |
| diode_sel | output | 2 | Photodiode mode |
| width_sel | output | 2 | Integration width code |
| gain_sel | output | 2 | Range code |
| persist_sel | output | 2 | Interrupt persistence code |
| int_flag | output | 1 | Interrupt status flag |
| thr_hi | output | 8 | Upper threshold byte |
| thr_lo | output | 8 | Lower threshold byte |
| sync_pulse | output | 1 | One-cycle integration sync strobe |
| clr_pulse | output | 1 | One-cycle interrupt clear strobe |

## Verification
The assertions assume a well-formed bus. SCL stays high or low for several system clocks, and SDA changes only while SCL is low, except when the host makes a start or stop. Under these conditions the two-flop samplers see each SCL edge once and never mistake a data change for a start or stop. The bench drives every bus phase for six system clocks and moves SDA only a quarter period after SCL falls. Random register values and pointers are mixed with directed cases: address mismatch, an aborted write, read-only writes, combined strobes and flag races.

// File: rtl/lsense_pkg.sv
package lsense_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_REG, ST_RACK,
    ST_WDATA, ST_WACK, ST_RDATA, ST_MACK
  } bus_state_t;

  // command register: bit 4 is reserved and never stored
  function automatic logic [7:0] cmd_store(input logic [7:0] w);
    return w & 8'hEF;
  endfunction

  // interrupt flag next value; clear has priority over set
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    if (clr) return 1'b0;
    if (set) return 1'b1;
    return cur;
  endfunction

  function automatic logic [7:0] ctrl_view(input logic flag,
                                           input logic [3:0] cfg);
    return {2'b00, flag, 1'b0, cfg};
  endfunction
endpackage

// File: rtl/lsense_line_sync.sv
module lsense_line_sync #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_LEN-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_LEN-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_LEN-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[SYNC_LEN-1];
  assign sda_s     = sda_pipe[SYNC_LEN-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/lsense_i2c_fsm.sv
module lsense_i2c_fsm
  import lsense_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       reg_evt,
  output logic       wr_evt,
  output logic [7:0] rx_byte
);
  bus_state_t st;
  logic [7:0] shreg, txreg;
  logic [3:0] cnt;
  logic       rw, host_nak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; shreg <= '0; txreg <= '1; cnt <= '0;
      rw <= 1'b0; host_nak <= 1'b1; reg_evt <= 1'b0; wr_evt <= 1'b0;
    end else begin
      reg_evt <= 1'b0;
      wr_evt  <= 1'b0;
      if (start_det) begin
        st <= ST_ADDR; cnt <= '0;
      end else if (stop_det) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_ADDR, ST_REG, ST_WDATA: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  st <= ST_AACK; rw <= shreg[0];
                end else st <= ST_IDLE;
              end else if (st == ST_REG) begin
                st <= ST_RACK; reg_evt <= 1'b1;
              end else begin
                st <= ST_WACK; wr_evt <= 1'b1;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            if (rw) begin st <= ST_RDATA; txreg <= rd_byte; cnt <= '0; end
            else st <= ST_REG;
          end
          ST_RACK, ST_WACK: if (scl_fall) st <= ST_WDATA;
          ST_RDATA: if (scl_fall) begin
            txreg <= {txreg[6:0], 1'b1};
            cnt   <= cnt + 4'd1;
            if (cnt == 4'd7) st <= ST_MACK;
          end
          ST_MACK: begin
            if (scl_rise) host_nak <= sda_s;
            else if (scl_fall) begin
              if (host_nak) st <= ST_IDLE;
              else begin st <= ST_RDATA; txreg <= rd_byte; cnt <= '0; end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rx_byte = shreg;
  assign sda_oe  = (st == ST_AACK) || (st == ST_RACK) || (st == ST_WACK) ||
                   ((st == ST_RDATA) && !txreg[7]);

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (st == ST_IDLE));
  // R1
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR));
endmodule

// File: rtl/lsense_regfile.sv
module lsense_regfile
  import lsense_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_evt,
  input  logic        wr_evt,
  input  logic [7:0]  rx_byte,
  input  logic        alarm_set_i,
  input  logic [15:0] sensor_i,
  input  logic [15:0] timer_i,
  output logic [7:0]  rd_byte,
  output logic [7:0]  cmd_q,
  output logic [3:0]  ctrl_cfg,
  output logic        flag_q,
  output logic [7:0]  thr_hi_q,
  output logic [7:0]  thr_lo_q,
  output logic        sync_pulse,
  output logic        clr_pulse
);
  logic [PTR_W-1:0] ptr;
  logic clr_req, wr_cmd, wr_ctrl, wr_hi, wr_lo;

  assign clr_req = reg_evt & rx_byte[6];
  assign wr_cmd  = wr_evt && ptr == 6'd0;
  assign wr_ctrl = wr_evt && ptr == 6'd1;
  assign wr_hi   = wr_evt && ptr == 6'd2;
  assign wr_lo   = wr_evt && ptr == 6'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; cmd_q <= '0; ctrl_cfg <= '0; flag_q <= 1'b0;
      thr_hi_q <= 8'hFF; thr_lo_q <= 8'h00;
      sync_pulse <= 1'b0; clr_pulse <= 1'b0;
    end else begin
      sync_pulse <= reg_evt & rx_byte[7];
      clr_pulse  <= clr_req;
      if (reg_evt) ptr <= rx_byte[PTR_W-1:0];
      if (wr_cmd)  cmd_q <= cmd_store(rx_byte);
      if (wr_ctrl) ctrl_cfg <= rx_byte[3:0];
      if (wr_hi)   thr_hi_q <= rx_byte;
      if (wr_lo)   thr_lo_q <= rx_byte;
      flag_q <= flag_next(flag_q, alarm_set_i,
                          clr_req | (wr_ctrl & ~rx_byte[5]));
    end
  end

  always_comb begin
    unique case (ptr)
      6'd0:    rd_byte = cmd_q;
      6'd1:    rd_byte = ctrl_view(flag_q, ctrl_cfg);
      6'd2:    rd_byte = thr_hi_q;
      6'd3:    rd_byte = thr_lo_q;
      6'd4:    rd_byte = sensor_i[7:0];
      6'd5:    rd_byte = sensor_i[15:8];
      6'd6:    rd_byte = timer_i[7:0];
      6'd7:    rd_byte = timer_i[15:8];
      default: rd_byte = 8'h00;
    endcase
  end

  // R5
  sync_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);
  // R6
  clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> !flag_q);
  // R8
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(alarm_set_i));
  // R4
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> ($stable(thr_hi_q) && $stable(thr_lo_q)));
endmodule

// File: rtl/lsense_i2c_regs.sv
module lsense_i2c_regs
  import lsense_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100,
  parameter int         SYNC_LEN = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [15:0] sensor_i,
  input  logic [15:0] timer_i,
  input  logic        alarm_set_i,
  output logic        adc_enable,
  output logic        adc_powerdown,
  output logic        ext_timing,
  output logic [1:0]  diode_sel,
  output logic [1:0]  width_sel,
  output logic [1:0]  gain_sel,
  output logic [1:0]  persist_sel,
  output logic        int_flag,
  output logic [7:0]  thr_hi,
  output logic [7:0]  thr_lo,
  output logic        sync_pulse,
  output logic        clr_pulse
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic reg_evt, wr_evt;
  logic [7:0] rx_byte, rd_byte, cmd_q;
  logic [3:0] ctrl_cfg;

  lsense_line_sync #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  lsense_i2c_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .sda_oe(sda_oe), .reg_evt(reg_evt),
    .wr_evt(wr_evt), .rx_byte(rx_byte));

  lsense_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .reg_evt(reg_evt), .wr_evt(wr_evt),
    .rx_byte(rx_byte), .alarm_set_i(alarm_set_i), .sensor_i(sensor_i),
    .timer_i(timer_i), .rd_byte(rd_byte), .cmd_q(cmd_q),
    .ctrl_cfg(ctrl_cfg), .flag_q(int_flag), .thr_hi_q(thr_hi),
    .thr_lo_q(thr_lo), .sync_pulse(sync_pulse), .clr_pulse(clr_pulse));

  assign adc_enable    = cmd_q[7];
  assign adc_powerdown = cmd_q[6];
  assign ext_timing    = cmd_q[5];
  assign diode_sel     = cmd_q[3:2];
  assign width_sel     = cmd_q[1:0];
  assign gain_sel      = ctrl_cfg[3:2];
  assign persist_sel   = ctrl_cfg[1:0];
endmodule

// File: tb/lsense_i2c_regs_tb.sv
module lsense_i2c_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [7:0] AW = 8'h88, AR = 8'h89;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [15:0] sensor_i = 16'h0, timer_i = 16'h0;
  logic alarm_set_i = 1'b0;
  logic sda_oe, adc_enable, adc_powerdown, ext_timing, int_flag;
  logic [1:0] diode_sel, width_sel, gain_sel, persist_sel;
  logic [7:0] thr_hi, thr_lo;
  logic sync_pulse, clr_pulse;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0, n_sync = 0, n_clr = 0;
  logic [7:0] m_cmd, m_hi, m_lo;
  logic [3:0] m_cfg;
  logic       m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsense_i2c_regs u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .sensor_i(sensor_i), .timer_i(timer_i),
    .alarm_set_i(alarm_set_i), .adc_enable(adc_enable),
    .adc_powerdown(adc_powerdown), .ext_timing(ext_timing),
    .diode_sel(diode_sel), .width_sel(width_sel), .gain_sel(gain_sel),
    .persist_sel(persist_sel), .int_flag(int_flag), .thr_hi(thr_hi),
    .thr_lo(thr_lo), .sync_pulse(sync_pulse), .clr_pulse(clr_pulse));

  always @(negedge clk) begin
    if (sync_pulse) n_sync++;
    if (clr_pulse)  n_clr++;
  end

  function automatic logic [7:0] exp_cmd(input logic [7:0] w);
    return {w[7:5], 1'b0, w[3:0]};
  endfunction
  function automatic logic [7:0] exp_ctrl(input logic f, input logic [3:0] c);
    logic [7:0] r;
    r = 8'h00; r[5] = f; r[3:0] = c;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic i2c_bit(input logic b, output logic s);
    sda_m = b; wt(Q); scl_m = 1'b1; wt(Q);
    s = sda_bus; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic nak);
    logic s;
    for (int i = 7; i >= 0; i--) i2c_bit(v[i], s);
    i2c_bit(1'b1, nak);
  endtask

  task automatic rbyte(input logic nak, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      i2c_bit(1'b1, s);
      v[i] = s;
    end
    i2c_bit(nak, s);
  endtask

  task automatic wr_reg(input logic [7:0] rb, input logic [7:0] d);
    logic a;
    i2c_start; wbyte(AW, a); wbyte(rb, a); wbyte(d, a); i2c_stop;
  endtask

  task automatic rd_reg(input logic [7:0] rb, output logic [7:0] v);
    logic a;
    i2c_start; wbyte(AW, a); wbyte(rb, a);
    i2c_start; wbyte(AR, a); rbyte(1'b1, v); i2c_stop;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary;
  end

  initial begin
    logic [7:0] v, d;
    logic a;
    int c0;
    void'($urandom(32'd4711));
    wt(4); rst_n = 1'b1; wt(4);

    // R7 reset state
    chk("R7 thr_hi", {8'h0, thr_hi}, 16'h00FF);
    chk("R7 thr_lo", {8'h0, thr_lo}, 16'h0000);
    chk("R7 fields", {9'h0, adc_enable, adc_powerdown, ext_timing,
        diode_sel, width_sel}, 16'h0);
    chk("R7 flag/sda", {14'h0, int_flag, sda_oe}, 16'h0);
    m_cmd = 8'h00; m_hi = 8'hFF; m_lo = 8'h00; m_cfg = 4'h0; m_flag = 1'b0;

    // R1 address acknowledge
    i2c_start; wbyte(AW, a); chk("R1 match ack", {15'h0, a}, 16'h0);
    wbyte(8'h02, a); wbyte(8'h3C, a); i2c_stop; m_hi = 8'h3C;
    chk("R1 write via match", {8'h0, thr_hi}, {8'h0, m_hi});
    i2c_start; wbyte(8'h8A, a); chk("R1 mismatch nak", {15'h0, a}, 16'h1);
    wbyte(8'h02, a); wbyte(8'h77, a); i2c_stop;
    chk("R1 mismatch no write", {8'h0, thr_hi}, {8'h0, m_hi});

    // R2 R3 R9 random register writes and read-back
    for (int it = 0; it < 28; it++) begin
      logic [7:0] p;
      p = 8'($urandom % 4);
      d = 8'($urandom);
      wr_reg(p, d);
      case (p[1:0])
        2'd0: m_cmd = exp_cmd(d);
        2'd1: begin m_cfg = d[3:0]; if (!d[5]) m_flag = 1'b0; end
        2'd2: m_hi = d;
        default: m_lo = d;
      endcase
      rd_reg(p, v);
      case (p[1:0])
        2'd0: chk("R2 R3 cmd readback", {8'h0, v}, {8'h0, m_cmd});
        2'd1: chk("R9 R3 ctrl readback", {8'h0, v},
                  {8'h0, exp_ctrl(m_flag, m_cfg)});
        2'd2: chk("R3 thr_hi readback", {8'h0, v}, {8'h0, m_hi});
        default: chk("R3 thr_lo readback", {8'h0, v}, {8'h0, m_lo});
      endcase
      chk("R2 cmd fields", {8'h0, adc_enable, adc_powerdown, ext_timing,
          1'b0, diode_sel, width_sel}, {8'h0, m_cmd});
      chk("R9 ctrl fields", {12'h0, gain_sel, persist_sel}, {12'h0, m_cfg});
    end

    // R2 reserved bit and all-ones
    wr_reg(8'h00, 8'hFF); rd_reg(8'h00, v); m_cmd = 8'hEF;
    chk("R2 reserved bit4", {8'h0, v}, 16'h00EF);
    // R9 reserved bits dropped; flag is 0 and writing 1 does not set it (R8)
    wr_reg(8'h01, 8'hFF); rd_reg(8'h01, v); m_cfg = 4'hF;
    chk("R9 R8 ctrl all ones", {8'h0, v}, 16'h000F);

    // R4 R3 read-only data bytes
    sensor_i = 16'($urandom); timer_i = 16'($urandom);
    rd_reg(8'h04, v); chk("R4 sensor lo", {8'h0, v}, {8'h0, sensor_i[7:0]});
    rd_reg(8'h05, v); chk("R4 sensor hi", {8'h0, v}, {8'h0, sensor_i[15:8]});
    rd_reg(8'h06, v); chk("R4 timer lo", {8'h0, v}, {8'h0, timer_i[7:0]});
    wr_reg(8'h07, 8'h00); rd_reg(8'h07, v);
    chk("R4 timer hi after write", {8'h0, v}, {8'h0, timer_i[15:8]});
    wr_reg(8'h09, 8'h55); rd_reg(8'h09, v);
    chk("R3 unmapped reads zero", {8'h0, v}, 16'h0);
    chk("R4 no side write", {thr_hi, thr_lo}, {m_hi, m_lo});
    rd_reg(8'h00, v); chk("R4 cmd kept", {8'h0, v}, {8'h0, m_cmd});

    // R5 sync strobe together with a pointer update and data write
    c0 = n_sync; wr_reg(8'h82, 8'h5A); m_hi = 8'h5A;
    chk("R5 sync count", 16'(n_sync - c0), 16'd1);
    chk("R5 pointer from same byte", {8'h0, thr_hi}, {8'h0, m_hi});

    // R8 flag set, write-1 keeps, write-0 clears
    @(negedge clk); alarm_set_i = 1'b1; @(negedge clk); alarm_set_i = 1'b0;
    wt(2); chk("R8 flag set", {15'h0, int_flag}, 16'h1);
    wr_reg(8'h01, 8'h20); chk("R8 write one keeps", {15'h0, int_flag}, 16'h1);
    rd_reg(8'h01, v); chk("R8 R9 flag readback", {8'h0, v}, 16'h0020);
    wr_reg(8'h01, 8'h00); chk("R8 write zero clears", {15'h0, int_flag}, 16'h0);

    // R6 clear strobe
    @(negedge clk); alarm_set_i = 1'b1; @(negedge clk); alarm_set_i = 1'b0;
    c0 = n_clr;
    i2c_start; wbyte(AW, a); wbyte(8'h40, a); i2c_stop;
    chk("R6 clr count", 16'(n_clr - c0), 16'd1);
    chk("R6 flag cleared", {15'h0, int_flag}, 16'h0);

    // R11 stop before data byte, pointer kept
    i2c_start; wbyte(AW, a); wbyte(8'h03, a); i2c_stop;
    chk("R11 no write", {8'h0, thr_lo}, {8'h0, m_lo});
    i2c_start; wbyte(AR, a); rbyte(1'b1, v); i2c_stop;
    chk("R11 R3 pointer kept", {8'h0, v}, {8'h0, m_lo});

    // R10 bus released after NAK and in idle
    wt(4); chk("R10 released", {15'h0, sda_oe}, 16'h0);
    summary;
  end
endmodule